// File: doc/BRIEF.md
# Strobe-latched 1K x 1 static memory

A one-bit-wide static memory of 1024 words, modelled synchronously. A free-running system clock samples an active-low chip-enable strobe, an active-low write strobe, a 10-bit address and a data-in bit. A memory cycle opens when the chip-enable strobe is seen going low. At that moment the address is captured, and the cycle lasts until the strobe is seen high again. Between cycles the strobe has to stay high for a minimum number of samples, the precharge time. A fall that comes too early is refused and reported on an error flag.

Read cycles give first an output-enable indication and, a parameterised number of clocks later, valid data for the captured word. A write runs while both strobes are low. It is committed by whichever strobe is seen rising first, using the data bit sampled with that rising sample. With the write strobe held low across several enable cycles, each enable rise stores one word. A short write-strobe pulse placed after the read data has become valid gives a read-then-write cycle on a single captured address. Pad-level tri-state drivers are not part of the block: the output-enable flag tells the pad logic when to drive.

Top module: `strobe_sram`

## Requirements
- R1: After reset, `q_oe`, `q_vld`, `q` and `pre_err` are 0, and every word of the array reads 0.
- R2: The address is captured from the same clock sample that first sees `e_n` low (only if that fall is accepted). Address changes after that sample have no effect on the cycle.
- R3: In the clock after a sample with `e_n` high, `q_oe` and `q_vld` are 0, and the cycle has ended.
- R4: For a read (`w_n` high), with the first low sample of `e_n` taken at edge t, `q_oe` is 1 from edge t+1 and `q_vld` is 1 from edge t+ACCESS_LAT. While `q_vld` is 1, `q` carries the word at the captured address. While `q_vld` is 0, `q` is 0.
- R5: Inside an accepted cycle, a write strobe seen rising while `e_n` is still low stores the `d` bit sampled at that same rising sample into the captured word, once.
- R6: A write strobe that is low on the sample before `e_n` is seen rising makes that rise commit `d`, sampled with the rise. With `w_n` held low, each of several consecutive cycles stores one word.
- R7: From the first sample in a cycle with `w_n` low until `e_n` is seen high, `q_oe` and `q_vld` stay 0. This holds even after `w_n` returns high.
- R8: In a cycle that has delivered valid read data, a later write-strobe pulse stores the `d` value present at its rising sample. Earlier changes of `d` during the pulse are discarded.
- R9: A fall of `e_n` seen after fewer than PRECHARGE consecutive high samples is ignored. `pre_err` is 1 for exactly one clock, one edge after that fall sample. No output is enabled and no write happens until the next accepted fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| e_n | input | 1 | Active-low chip-enable strobe |
| w_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Word address, captured when a cycle opens |
| d | input | 1 | Data bit to be written |
| q | output | 1 | Read data; 0 when not valid |
| q_oe | output | 1 | Output-enable indication (0 means high impedance) |
| q_vld | output | 1 | Read data on `q` is valid |
| pre_err | output | 1 | One-clock pulse when a strobe fall is refused for precharge |

## Verification
The assertions rely on each strobe being a clean level between clock samples. They also rely on a cycle being closed only by a rise of the enable strobe, so that an enable fall never arrives while a cycle is open. The bench changes every input on the falling clock edge only and opens a new cycle only after closing the previous one. It keeps the enable strobe high for exactly PRECHARGE samples between cycles. The only exception is the single deliberate precharge violation, where the strobe is held high for just one sample.

// File: rtl/strobe_sram_pkg.sv
package strobe_sram_pkg;

   // Strobe events derived from two successive clock samples.
   typedef struct packed {
      logic e_lo;      // current enable sample is low
      logic e_fall;    // enable seen going low
      logic e_rise;    // enable seen going high
      logic w_lo;      // current write sample is low
      logic w_rise;    // write seen going high
      logic w_was_lo;  // previous write sample was low
   } strobe_ev_t;

   localparam int unsigned STROBES = 2;
   localparam int unsigned IDX_E   = 0;
   localparam int unsigned IDX_W   = 1;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sr_in_stage.sv
module sr_in_stage
   import strobe_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              e_n,
   input  logic              w_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              d,
   output strobe_ev_t        ev,
   output logic [ADDR_W-1:0] addr_s,
   output logic              d_s
);

   logic [STROBES-1:0] raw;
   logic [STROBES-1:0] cur;
   logic [STROBES-1:0] prv;
   logic [STROBES-1:0] fall;
   logic [STROBES-1:0] rise;

   assign raw[IDX_E] = e_n;
   assign raw[IDX_W] = w_n;

   for (genvar g = 0; g < STROBES; g++) begin : g_strobe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cur[g] <= 1'b1;
            prv[g] <= 1'b1;
         end else begin
            cur[g] <= raw[g];
            prv[g] <= cur[g];
         end
      end
      assign fall[g] = prv[g] & ~cur[g];
      assign rise[g] = ~prv[g] & cur[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_s <= '0;
         d_s    <= 1'b0;
      end else begin
         addr_s <= addr;
         d_s    <= d;
      end
   end

   always_comb begin
      ev.e_lo     = ~cur[IDX_E];
      ev.e_fall   = fall[IDX_E];
      ev.e_rise   = rise[IDX_E];
      ev.w_lo     = ~cur[IDX_W];
      ev.w_rise   = rise[IDX_W];
      ev.w_was_lo = ~prv[IDX_W];
   end

endmodule

// File: rtl/sr_cycle_ctrl.sv
module sr_cycle_ctrl
   import strobe_sram_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned ACCESS_LAT = 3,
   parameter int unsigned PRECHARGE  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobe_ev_t        ev,
   input  logic [ADDR_W-1:0] addr_s,
   output logic [ADDR_W-1:0] addr_lat,
   output logic              commit,
   output logic              q_oe,
   output logic              q_vld,
   output logic              err
);

   localparam int unsigned PC_W  = cnt_width(PRECHARGE);
   localparam int unsigned LAT_W = cnt_width(ACCESS_LAT);
   localparam logic [PC_W-1:0]  PC_MAX  = PC_W'(PRECHARGE);
   localparam logic [LAT_W-1:0] LAT_MAX = LAT_W'(ACCESS_LAT);

   logic [PC_W-1:0]  hi_cnt;
   logic [LAT_W-1:0] lat;
   logic             active;
   logic             wr_seen;
   logic             start_ok;

   assign start_ok = ev.e_fall & (hi_cnt >= PC_MAX);

   // Precharge: consecutive high samples of the enable strobe, saturating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hi_cnt <= PC_MAX;
      else if (ev.e_lo)         hi_cnt <= '0;
      else if (hi_cnt < PC_MAX) hi_cnt <= hi_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         wr_seen  <= 1'b0;
         lat      <= '0;
         addr_lat <= '0;
         err      <= 1'b0;
      end else begin
         err <= ev.e_fall & ~start_ok;
         if (start_ok) begin
            active   <= 1'b1;
            addr_lat <= addr_s;
            lat      <= LAT_W'(1);
            wr_seen  <= ev.w_lo;
         end else if (ev.e_rise) begin
            active  <= 1'b0;
            wr_seen <= 1'b0;
         end else if (active) begin
            wr_seen <= wr_seen | ev.w_lo;
            if (lat < LAT_MAX) lat <= lat + 1'b1;
         end
      end
   end

   // A write ends on whichever strobe is seen rising first.
   assign commit = active & ((ev.w_rise & ev.e_lo) | (ev.e_rise & ev.w_was_lo));

   assign q_oe  = active & ev.e_lo & ~ev.w_lo & ~wr_seen;
   assign q_vld = q_oe & (lat == LAT_MAX);

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ev.e_fall) |=> $stable(addr_lat));

   assert_rise_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev.e_rise |=> !active);

   assert_one_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

   assert_oe_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && wr_seen && !ev.e_rise) |=> !q_oe);

   assert_err_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !active);

endmodule

// File: rtl/sr_bit_array.sv
module sr_bit_array #(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              wdata,
   output logic              rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0] cells;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cells[i] <= 1'b0;
         else if (we && (addr == ADDR_W'(i))) cells[i] <= wdata;
      end
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/strobe_sram.sv
module strobe_sram
   import strobe_sram_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned ACCESS_LAT = 3,
   parameter int unsigned PRECHARGE  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              e_n,
   input  logic              w_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              d,
   output logic              q,
   output logic              q_oe,
   output logic              q_vld,
   output logic              pre_err
);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("strobe_sram: ADDR_W must lie in 1..12");
   end
   if (ACCESS_LAT < 1) begin : g_bad_lat
      $error("strobe_sram: ACCESS_LAT must be at least 1");
   end
   if (PRECHARGE < 1) begin : g_bad_pre
      $error("strobe_sram: PRECHARGE must be at least 1");
   end

   strobe_ev_t        ev;
   logic [ADDR_W-1:0] addr_s;
   logic [ADDR_W-1:0] addr_lat;
   logic              d_s;
   logic              commit;
   logic              rdata;

   sr_in_stage #(.ADDR_W(ADDR_W)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .e_n    (e_n),
      .w_n    (w_n),
      .addr   (addr),
      .d      (d),
      .ev     (ev),
      .addr_s (addr_s),
      .d_s    (d_s)
   );

   sr_cycle_ctrl #(
      .ADDR_W     (ADDR_W),
      .ACCESS_LAT (ACCESS_LAT),
      .PRECHARGE  (PRECHARGE)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .addr_s   (addr_s),
      .addr_lat (addr_lat),
      .commit   (commit),
      .q_oe     (q_oe),
      .q_vld    (q_vld),
      .err      (pre_err)
   );

   sr_bit_array #(.ADDR_W(ADDR_W)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr_lat),
      .we    (commit),
      .wdata (d_s),
      .rdata (rdata)
   );

   assign q = q_vld & rdata;

   assert_vld_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      q_vld |=> (q_vld || !q_oe));

endmodule

// File: tb/strobe_sram_tb.sv
`timescale 1ns/1ps
module strobe_sram_tb;

   localparam int AW  = 4;
   localparam int LAT = 3;
   localparam int PRE = 2;
   localparam int N   = 1 << AW;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          e_n   = 1'b1;
   logic          w_n   = 1'b1;
   logic          d     = 1'b0;
   logic [AW-1:0] addr  = '0;
   logic          q, q_oe, q_vld, pre_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit refm [N];

   always #2.5 clk = ~clk;

   strobe_sram #(.ADDR_W(AW), .ACCESS_LAT(LAT), .PRECHARGE(PRE)) u_dut (
      .clk(clk), .rst_n(rst_n), .e_n(e_n), .w_n(w_n), .addr(addr), .d(d),
      .q(q), .q_oe(q_oe), .q_vld(q_vld), .pre_err(pre_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic bit pat(input int a, input int k);
      return bit'((((a * 7) >> 2) ^ a ^ k) & 1);
   endfunction

   task automatic close_cycle();
      e_n = 1'b1;
      tick();
      chk("R3 q_oe after enable high", int'(q_oe), 0);
      chk("R3 q_vld after enable high", int'(q_vld), 0);
      repeat (PRE - 1) tick();
   endtask

   task automatic do_read(input int a, input string req);
      addr = AW'(a); e_n = 1'b0; w_n = 1'b1;
      tick();
      chk("R4 q_oe in fall sample clock", int'(q_oe), 0);
      addr = ~AW'(a);   // R2: late address change must not matter
      for (int j = 1; j <= LAT; j++) begin
         tick();
         chk("R4 q_oe during read", int'(q_oe), 1);
         if (j < LAT) begin
            chk("R4 q_vld before latency", int'(q_vld), 0);
            chk("R4 q zero while not valid", int'(q), 0);
         end
      end
      chk("R4 q_vld at latency", int'(q_vld), 1);
      chk(req, int'(q), int'(refm[a]));
      chk("R9 pre_err quiet on accepted cycle", int'(pre_err), 0);
      close_cycle();
   endtask

   // by_e = 0: write strobe terminates; by_e = 1: enable terminates
   task automatic do_write(input int a, input bit v, input bit by_e);
      addr = AW'(a); e_n = 1'b0; d = ~v;
      if (!by_e) w_n = 1'b1;
      tick();
      addr = ~AW'(a);
      w_n = 1'b0;
      tick();
      chk("R7 q_oe low once write strobe low", int'(q_oe), 0);
      d = v;
      tick();
      if (!by_e) begin
         w_n = 1'b1;
         tick();
         d = ~v;
         tick();
         chk("R7 q_oe stays low after write strobe rise", int'(q_oe), 0);
         close_cycle();
      end else begin
         e_n = 1'b1;
         tick();
         chk("R6 q_oe low after enable rise", int'(q_oe), 0);
         d = ~v;
         repeat (PRE - 1) tick();
      end
      refm[a] = v;
   endtask

   task automatic do_rmw(input int a, input bit v);
      addr = AW'(a); e_n = 1'b0; w_n = 1'b1;
      tick();
      repeat (LAT) tick();
      chk("R8 read phase valid", int'(q_vld), 1);
      chk("R8 read phase data", int'(q), int'(refm[a]));
      w_n = 1'b0; d = ~v;
      tick();
      chk("R8 q_oe off in write phase", int'(q_oe), 0);
      d = v;  tick();
      d = ~v; tick();
      d = v;  w_n = 1'b1;
      tick();
      d = ~v;
      tick();
      chk("R7 q_oe stays off after pulse", int'(q_oe), 0);
      chk("R7 q_vld stays off after pulse", int'(q_vld), 0);
      close_cycle();
      refm[a] = v;
   endtask

   task automatic precharge_violation(input int a, input int b);
      addr = AW'(a); e_n = 1'b0; w_n = 1'b1;
      tick();
      tick();
      e_n = 1'b1;
      tick();
      e_n = 1'b0; w_n = 1'b0; d = ~refm[b]; addr = AW'(b);
      tick();
      chk("R9 pre_err not yet", int'(pre_err), 0);
      tick();
      chk("R9 pre_err pulse", int'(pre_err), 1);
      chk("R9 q_oe off on refused fall", int'(q_oe), 0);
      w_n = 1'b1;
      tick();
      chk("R9 pre_err one clock only", int'(pre_err), 0);
      chk("R9 q_oe stays off", int'(q_oe), 0);
      w_n = 1'b0;
      repeat (LAT) tick();
      chk("R9 q_vld stays off", int'(q_vld), 0);
      e_n = 1'b1;
      tick();
      w_n = 1'b1;
      repeat (PRE - 1) tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R4 watchdog act=0 exp=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) refm[i] = 1'b0;
      repeat (3) tick();
      chk("R1 q_oe in reset", int'(q_oe), 0);
      chk("R1 q_vld in reset", int'(q_vld), 0);
      chk("R1 q in reset", int'(q), 0);
      chk("R1 pre_err in reset", int'(pre_err), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 q_oe after reset", int'(q_oe), 0);

      for (int a = 0; a < N; a++) do_read(a, "R1 array cleared by reset");

      for (int a = 0; a < N; a++) do_write(a, pat(a, 0), bit'(a & 1));
      for (int a = 0; a < N; a++) do_read(a, "R5 R6 stored data");

      w_n = 1'b0;  // R6: write strobe held low across cycles
      for (int a = N - 1; a >= 0; a--) do_write(a, pat(a, 1), 1'b1);
      w_n = 1'b1;
      for (int a = 0; a < N; a++) do_read(a, "R6 back-to-back writes");

      for (int a = 0; a < N; a += 3) do_rmw(a, ~refm[a]);
      for (int a = 0; a < N; a++) do_read(a, "R8 read-then-write result");

      precharge_violation(1, 6);
      do_read(6, "R9 refused fall wrote nothing");
      do_read(1, "R2 R9 neighbour untouched");

      for (int a = 0; a < N; a += 5) do_write(a, ~refm[a], 1'b0);
      for (int a = 0; a < N; a += 5) do_read(a, "R2 R5 rewrite check");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule